// File: doc/BRIEF.md
# Periodic Interval Timer

The block produces a steady stream of timing events for a processor. A fixed divide-by-16 prescaler feeds a 20-bit interval counter. The counter climbs from zero to a programmed limit and then wraps to zero. Each wrap completes one period: it sets an event flag and adds one to a 12-bit tally of completed periods. Software reaches the block through a simple word-wide register bus. It can read the count and the tally in two ways: through an acknowledging view that clears the event, or through a plain image that changes nothing. A level interrupt follows the event flag whenever the interrupt is enabled.

A small state machine decides whether the counter runs. There are three states:
- `ST_HALT`: stopped, with the count at zero.
- `ST_RUN`: counting.
- `ST_DRAIN`: the enable has been removed, and the counter is finishing its current period.

The transitions are:
- `HALT_TO_RUN` when the enable is set.
- `RUN_TO_DRAIN` when the enable is cleared away from a wrap.
- `RUN_TO_HALT` when the enable is cleared in the cycle a wrap occurs.
- `DRAIN_TO_RUN` when the enable is set again.
- `DRAIN_TO_HALT` on the wrap that ends the period.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register decode uses `bus_addr[3:2]`:
  - offset 0x0 selects the control word;
  - offset 0x4 selects the event status;
  - offset 0x8 selects the acknowledging counter view;
  - offset 0xC selects the plain image.
  
  In the control word, bits 19:0 hold the limit, bit 24 is the run enable and bit 25 is the interrupt enable. All other bits read zero. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: While running, the interval count advances by one exactly once every 16 clock cycles.
- R4: The count goes 0, 1, …, L (L is the programmed limit) and then wraps to 0, so successive wraps are 16·(L+1) cycles apart.
- R5: Both counter views carry the tally in bits 31:20 and the count in bits 19:0. Each wrap adds one to the tally and sets status bit 0.
- R6: Reading the plain image at 0xC leaves the status flag and the tally unchanged.
- R7: A read at 0x8 returns the tally and count as they stood before the read, then clears the status flag and the tally.
- R8: The tally saturates at 4095 instead of wrapping.
- R9: If a wrap and an acknowledging read fall in the same cycle, the tally ends at 1 and the status flag stays set.
- R10: `irq` is high exactly when the status flag and the interrupt enable are both set. Clearing the interrupt enable does not stop counting.
- R11: Clearing the run enable lets the counter run to the end of its current period (including that wrap's event), after which it holds at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
The counter runs with limits of 3, 1 and 0. Limit 3 exposes the tick spacing, the count sequence and the wrap-to-wrap distance as separate numbers. Limit 1 makes the wrap phase predictable enough to place an acknowledging read on the exact wrap cycle. Limit 0 produces a wrap every 16 cycles, which drives the tally past 4095 to test saturation.

The tests interleave plain-image reads and acknowledging reads, which separates the read that clears from the read that has no side effect. Removing the enable in the middle of a period separates a counter that finishes its period and then parks at zero from one that stops at once or never stops.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = 20;
    localparam int TALLY_W   = 12;
    localparam int PRE_W     = 4;
    localparam int RUN_BIT   = 24;
    localparam int IRQEN_BIT = 25;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ACKVW  = 2'd2,
        SEL_IMAGE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_e;

    typedef struct packed {
        logic             irq_en;
        logic             run_en;
        logic [CNT_W-1:0] limit;
    } ctrl_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    output logic [PW-1:0] phase,
    output logic          tick
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (!active)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign tick = active && (phase == {PW{1'b1}});
endmodule

// File: rtl/ivt_interval.sv
module ivt_interval #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          wrap
);
    // A limit lowered below the current count still ends the period.
    assign wrap = tick && (count >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= wrap ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/ivt_tally.sv
module ivt_tally #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic          ack,
    output logic [TW-1:0] tally,
    output logic          flag
);
    localparam logic [TW-1:0] ONE = TW'(1);
    localparam logic [TW-1:0] TOP = {TW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally <= '0;
            flag  <= 1'b0;
        end else if (ack) begin
            tally <= wrap ? ONE : '0;
            flag  <= wrap;
        end else if (wrap) begin
            if (tally != TOP)
                tally <= tally + 1'b1;
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int VIEW_W = TALLY_W + CNT_W;

    ctrl_t              ctrl_q;
    run_state_e         state_q, state_d;
    reg_sel_e           sel;
    logic               ack;
    logic               count_active;
    logic               tick_w;
    logic [PRE_W-1:0]   phase_w;
    logic [CNT_W-1:0]   count_w;
    logic               wrap_w;
    logic [TALLY_W-1:0] tally_w;
    logic               flag_w;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    logic               unused_bits;

    assign sel         = reg_sel_e'(bus_addr[3:2]);
    assign ack         = bus_re && (sel == SEL_ACKVW);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:IRQEN_BIT+1],
                           bus_wdata[RUN_BIT-1:CNT_W]};

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_we && (sel == SEL_CTRL)) begin
            ctrl_q.irq_en <= bus_wdata[IRQEN_BIT];
            ctrl_q.run_en <= bus_wdata[RUN_BIT];
            ctrl_q.limit  <= bus_wdata[CNT_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HALT;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl_q.run_en)
                    state_d = ST_RUN;                            // HALT_TO_RUN
            end
            ST_RUN: begin
                if (!ctrl_q.run_en)
                    state_d = wrap_w ? ST_HALT : ST_DRAIN;       // RUN_TO_HALT / RUN_TO_DRAIN
            end
            ST_DRAIN: begin
                if (ctrl_q.run_en)
                    state_d = ST_RUN;                            // DRAIN_TO_RUN
                else if (wrap_w)
                    state_d = ST_HALT;                           // DRAIN_TO_HALT
            end
            default: state_d = ST_HALT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        count_active = (state_q != ST_HALT);
        irq          = flag_w && ctrl_q.irq_en;
    end

    ivt_prescaler #(.PW(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (count_active),
        .phase  (phase_w),
        .tick   (tick_w)
    );

    ivt_interval #(.CW(CNT_W)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .limit (ctrl_q.limit),
        .count (count_w),
        .wrap  (wrap_w)
    );

    ivt_tally #(.TW(TALLY_W)) u_tal (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap_w),
        .ack   (ack),
        .tally (tally_w),
        .flag  (flag_w)
    );

    // read selection
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_mux[IRQEN_BIT]   = ctrl_q.irq_en;
                rd_mux[RUN_BIT]     = ctrl_q.run_en;
                rd_mux[CNT_W-1:0]   = ctrl_q.limit;
            end
            SEL_STATUS: rd_mux[0] = flag_w;
            SEL_ACKVW,
            SEL_IMAGE:  rd_mux[VIEW_W-1:0] = {tally_w, count_w};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_re)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [PRE_W-1:0]   phase,
    input logic [CNT_W-1:0]   count,
    input logic [TALLY_W-1:0] tally,
    input logic               flag,
    input logic               wrap,
    input logic               ack,
    input logic               irq_en,
    input logic               irq,
    input logic               active
);
    // R3
    count_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ($past(phase) == {PRE_W{1'b1}}));

    // R8
    tally_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tally < $past(tally)) |-> $past(ack));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (!flag && tally == '0));

    // R9
    ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (flag && tally == TALLY_W'(1)));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R11
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (count == '0));
endmodule

bind ivt_timer ivt_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase_w),
    .count  (count_w),
    .tally  (tally_w),
    .flag   (flag_w),
    .wrap   (wrap_w),
    .ack    (ack),
    .irq_en (ctrl_q.irq_en),
    .irq    (irq),
    .active (count_active)
);

// File: tb/sim_ivt_timer.sv
`timescale 1ns/1ps
module sim_ivt_timer;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_ACK  = 4'h8;
    localparam logic [3:0] A_IMG  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ivt_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // all tasks start and end at a falling edge
    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        foreach (v[i]) begin end
        do_read(A_CTRL, v); check(v == 0, "R1 control reset", v, 0);
        do_read(A_STAT, v); check(v == 0, "R1 status reset", v, 0);
        do_read(A_IMG,  v); check(v == 0, "R1 image reset", v, 0);
        do_read(A_ACK,  v); check(v == 0, "R1 ack view reset", v, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        do_write(A_CTRL, 32'hFEFA_BCDE);
        do_read(A_CTRL, v);
        check(v == 32'h020A_BCDE, "R2 control fields", v, 32'h020A_BCDE);
        do_read(A_IMG, v);
        check(v == 0, "R2 run enable clear keeps halted", v, 0);
        check(irq == 1'b0, "R10 irq without event", {31'b0, irq}, 0);
    endtask

    task automatic t_run();
        logic [31:0] v, prev, img, st;
        logic [19:0] exp_c;
        int last_chg = -1;
        int last_wrap = -1;
        int n_chg = 0;
        do_write(A_CTRL, 32'h0100_0003);
        do_read(A_IMG, prev);
        for (int i = 0; i < 300 && n_chg < 9; i++) begin
            do_read(A_IMG, v);
            if (v[19:0] != prev[19:0]) begin
                exp_c = (prev[19:0] == 20'd3) ? 20'd0 : prev[19:0] + 20'd1;
                check(v[19:0] == exp_c, "R4 count sequence", {12'b0, v[19:0]}, {12'b0, exp_c});
                if (last_chg >= 0)
                    check(cyc - last_chg == 16, "R3 tick spacing", cyc - last_chg, 16);
                last_chg = cyc;
                if (v[19:0] == 0) begin
                    check(v[31:20] == prev[31:20] + 12'd1, "R5 tally step", {20'b0, v[31:20]}, {20'b0, prev[31:20] + 12'd1});
                    if (last_wrap >= 0)
                        check(cyc - last_wrap == 64, "R4 wrap spacing", cyc - last_wrap, 64);
                    last_wrap = cyc;
                end
                n_chg++;
            end
            prev = v;
        end
        check(n_chg == 9, "R3 counter advancing", n_chg, 9);
        do_read(A_STAT, st);
        check(st == 1, "R5 status after wrap", st, 1);
        do_read(A_IMG, img);
        do_read(A_IMG, v);
        check(v[31:20] == img[31:20] && v[31:20] != 0, "R6 image keeps tally", v, img);
        do_read(A_STAT, st);
        check(st == 1, "R6 image keeps status", st, 1);
        do_read(A_ACK, v);
        check(v[31:20] == img[31:20], "R7 ack returns tally", v, img);
        do_read(A_STAT, st);
        check(st == 0, "R7 status cleared", st, 0);
        do_read(A_IMG, v);
        check(v[31:20] == 0, "R7 tally cleared", {20'b0, v[31:20]}, 0);
    endtask

    task automatic t_irq();
        logic [31:0] st, a, b;
        bit seen = 1'b0;
        do_write(A_CTRL, 32'h0300_0003);
        check(irq == 1'b0, "R10 irq low before event", {31'b0, irq}, 0);
        for (int i = 0; i < 100 && !seen; i++) begin
            do_read(A_STAT, st);
            seen = st[0];
        end
        check(seen, "R10 event arrives", {31'b0, seen}, 1);
        check(irq == 1'b1, "R10 irq with event and enable", {31'b0, irq}, 1);
        do_write(A_CTRL, 32'h0100_0003);
        check(irq == 1'b0, "R10 irq masked", {31'b0, irq}, 0);
        do_read(A_STAT, st);
        check(st == 1, "R10 mask keeps status", st, 1);
        do_read(A_IMG, a);
        idle(20);
        do_read(A_IMG, b);
        check(a[19:0] != b[19:0], "R10 counting continues", b, a);
    endtask

    task automatic t_drain();
        logic [31:0] v, st;
        bit saw3 = 1'b0;
        bit parked = 1'b0;
        for (int i = 0; i < 100; i++) begin
            do_read(A_IMG, v);
            if (v[19:0] == 20'd2) break;
        end
        do_read(A_ACK, v);
        do_write(A_CTRL, 32'h0000_0003);
        for (int i = 0; i < 100 && !parked; i++) begin
            do_read(A_IMG, v);
            if (v[19:0] == 20'd3) saw3 = 1'b1;
            if (v[19:0] == 20'd0) parked = 1'b1;
        end
        check(saw3, "R11 finishes period", {31'b0, saw3}, 1);
        check(parked, "R11 reaches zero", {31'b0, parked}, 1);
        check(v[31:20] == 12'd1, "R11 final wrap counted", {20'b0, v[31:20]}, 1);
        for (int k = 0; k < 5; k++) begin
            idle(20);
            do_read(A_IMG, v);
            check(v == 32'h0010_0000, "R11 holds at zero", v, 32'h0010_0000);
        end
        do_read(A_STAT, st);
        check(st == 1, "R11 status from final wrap", st, 1);
    endtask

    task automatic t_saturate();
        logic [31:0] v, st;
        do_write(A_CTRL, 32'h0100_0000);
        do_read(A_ACK, v);
        idle(4200 * 16);
        do_read(A_IMG, v);
        check(v[31:20] == 12'hFFF, "R8 tally saturates", {20'b0, v[31:20]}, 32'hFFF);
        check(v[19:0] == 0, "R4 limit zero count", {12'b0, v[19:0]}, 0);
        do_read(A_STAT, st);
        check(st == 1, "R8 status set", st, 1);
    endtask

    task automatic t_collide();
        logic [31:0] v, prev, st;
        bit found = 1'b0;
        do_write(A_CTRL, 32'h0100_0001);
        do_read(A_IMG, prev);
        for (int i = 0; i < 100 && !found; i++) begin
            do_read(A_IMG, v);
            if (prev[19:0] == 20'd1 && v[19:0] == 20'd0) found = 1'b1;
            prev = v;
        end
        check(found, "R9 wrap located", {31'b0, found}, 1);
        idle(30);
        do_read(A_ACK, v);
        do_read(A_IMG, v);
        check(v[31:20] == 12'd1, "R9 tally after collision", {20'b0, v[31:20]}, 1);
        do_read(A_STAT, st);
        check(st == 1, "R9 status kept", st, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_run();
        t_irq();
        t_drain();
        t_saturate();
        t_collide();
        done = 1'b1;
        report();
        $finish;
    end
endmodule